// File: doc/BRIEF.md
# Timer Output Waveform Generator

This block turns the compare-match strobes of a split timer into output waveforms. Each timer half has its own channel. A channel holds a status level that software can read. The timer clock is modelled as a one-cycle enable, `tick_i`, on the system clock. A match only counts when it arrives in a cycle with a tick.

Each channel runs in one of two modes. In pulse mode, a match makes the status active for a programmed number of timer ticks, from one to four. In clock mode, every match flips the status, so a steady run of matches gives a square wave. Only one channel drives a device pin. That pin copies the status of that channel, and an invert control can flip its polarity. The other channel has no pin, so its waveform can only be seen through its status bit. Detecting the match itself happens upstream of this block.

There is no streaming data here. All ports are plain control and status signals with no handshake, and the block never applies back-pressure.

Top module: `tmr_wave_gen`

## Requirements
- R1: While reset is asserted and after it, until the first qualified event, every status bit is 0 and `out_pin_o` equals `out_invert_i`.
- R2: In pulse mode (`clk_mode_i[c]`=0), a qualified match (`match_i[c]` and `tick_i[c]` high in the same cycle) makes `status_o[c]` equal 1 after the next clock edge. The width field `pulse_width_i[2c+1:2c]` sets the pulse length: 00, 01, 10 and 11 give 1, 2, 3 and 4 ticks. The status stays 1 until the edge of the tick that is width+1 ticks after the match, and then returns to 0.
- R3: A qualified match that arrives while a pulse is still active restarts the pulse. The remaining length is reloaded from the width field present at that match.
- R4: In clock mode (`clk_mode_i[c]`=1), every qualified match inverts `status_o[c]` at the next edge. The pulse length counter keeps its value while the channel is in clock mode.
- R5: A match without a tick has no effect. A status bit changes only after a cycle in which its own `tick_i[c]` is high.
- R6: `out_pin_o` equals `status_o[PIN_CH]` XOR `out_invert_i`, with no delay. When `out_invert_i` is 1, the pin rests high and goes low when its channel is active.
- R7: Channels are independent. Channel 1 has no pin; its status follows R2 to R5 using only its own tick, match, mode and width inputs.
- R8: The width field is sampled only at a qualified match. Changing it during an active pulse does not change that pulse's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | NCH | Per-channel timer clock enable |
| match_i | input | NCH | Per-channel compare-match strobe |
| clk_mode_i | input | NCH | 1 selects clock (toggle) mode, 0 selects pulse mode |
| pulse_width_i | input | NCH*WB | Per-channel pulse width field; channel c uses bits [WB*c+WB-1:WB*c] |
| out_invert_i | input | 1 | Pin polarity: 1 inverts the pin |
| out_pin_o | output | 1 | Output pin waveform of channel PIN_CH |
| status_o | output | NCH | Readable per-channel output state |

## Verification
The assertions check four things on every cycle. A clock-mode match flips the status, a pulse-mode match sets it, and the status never moves without a tick. The pin flips with its channel whenever the invert control is steady. A counter in the checker also bounds a pulse to at most four ticks after its last match. Some behaviours can only be shown by the bench scenarios, which compare each cycle against a reference model. These are the exact pulse length for each width code, the reload when a match restarts a pulse, ignoring width changes in the middle of a pulse, the behaviour when the mode switches with a pulse in flight, and channel independence under random mixed stimulus.

// File: rtl/tmr_wave_pkg.sv
package tmr_wave_pkg;

  typedef enum logic {
    MODE_PULSE = 1'b0,
    MODE_CLOCK = 1'b1
  } wave_mode_e;

  // Number of timer ticks a pulse lasts for a given width code.
  function automatic int unsigned ticks_for_code(input int unsigned code);
    return code + 1;
  endfunction

endpackage

// File: rtl/tmr_wave_len.sv
module tmr_wave_len #(
  parameter int WB = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [WB-1:0] load_val_i,
  input  logic          step_i,
  output logic          last_o
);

  logic [WB-1:0] remain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remain_q <= '0;
    end else if (load_i) begin
      remain_q <= load_val_i;
    end else if (step_i && remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign last_o = (remain_q == '0);

endmodule

// File: rtl/tmr_wave_chan.sv
module tmr_wave_chan
  import tmr_wave_pkg::*;
#(
  parameter int WB = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          match_i,
  input  wave_mode_e    mode_i,
  input  logic [WB-1:0] width_i,
  output logic          level_o
);

  logic level_q;
  logic level_d;
  logic hit;
  logic len_load;
  logic len_step;
  logic len_last;

  assign hit      = tick_i && match_i;
  assign len_load = hit && (mode_i == MODE_PULSE);
  assign len_step = tick_i && !match_i && (mode_i == MODE_PULSE) && level_q;

  tmr_wave_len #(.WB(WB)) u_len (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (len_load),
    .load_val_i (width_i),
    .step_i     (len_step),
    .last_o     (len_last)
  );

  always_comb begin
    level_d = level_q;
    if (tick_i) begin
      if (mode_i == MODE_CLOCK) begin
        if (match_i) level_d = !level_q;
      end else begin
        if (match_i)                  level_d = 1'b1;
        else if (level_q && len_last) level_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= 1'b0;
    else         level_q <= level_d;
  end

  assign level_o = level_q;

endmodule

// File: rtl/tmr_wave_gen.sv
module tmr_wave_gen
  import tmr_wave_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int WB     = 2,
  parameter int PIN_CH = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH-1:0]    tick_i,
  input  logic [NCH-1:0]    match_i,
  input  logic [NCH-1:0]    clk_mode_i,
  input  logic [NCH*WB-1:0] pulse_width_i,
  input  logic              out_invert_i,
  output logic              out_pin_o,
  output logic [NCH-1:0]    status_o
);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    wave_mode_e mode;
    assign mode = clk_mode_i[c] ? MODE_CLOCK : MODE_PULSE;
    tmr_wave_chan #(.WB(WB)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i[c]),
      .match_i (match_i[c]),
      .mode_i  (mode),
      .width_i (pulse_width_i[WB*c +: WB]),
      .level_o (status_o[c])
    );
  end

  assign out_pin_o = status_o[PIN_CH] ^ out_invert_i;

endmodule

// File: rtl/tmr_wave_chk.sv
module tmr_wave_chk #(
  parameter int NCH    = 2,
  parameter int WB     = 2,
  parameter int PIN_CH = 0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NCH-1:0]    tick_i,
  input logic [NCH-1:0]    match_i,
  input logic [NCH-1:0]    clk_mode_i,
  input logic [NCH*WB-1:0] pulse_width_i,
  input logic              out_invert_i,
  input logic              out_pin_o,
  input logic [NCH-1:0]    status_o
);

  localparam int MAXW = (1 << WB) - 1;

  for (genvar c = 0; c < NCH; c++) begin : g_c
    logic [WB+1:0] since_q;
    logic          pure_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        since_q <= '0;
        pure_q  <= 1'b0;
      end else begin
        if (tick_i[c] && match_i[c]) begin
          since_q <= '0;
          pure_q  <= !clk_mode_i[c];
        end else begin
          if (tick_i[c] && since_q != '1) since_q <= since_q + 1'b1;
          if (clk_mode_i[c]) pure_q <= 1'b0;
        end
      end
    end

    assert_clk_toggle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i[c] && match_i[c] && clk_mode_i[c]) |=> (status_o[c] != $past(status_o[c])));

    assert_pulse_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i[c] && match_i[c] && !clk_mode_i[c]) |=> status_o[c]);

    assert_no_tick_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i[c] |=> $stable(status_o[c]));

    assert_pulse_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pure_q && status_o[c]) |-> (since_q <= (WB+2)'(MAXW)));
  end

  assert_pin_follow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i[PIN_CH] && match_i[PIN_CH] && clk_mode_i[PIN_CH])
      |=> (out_pin_o != $past(out_pin_o)) || (out_invert_i != $past(out_invert_i)));

endmodule

bind tmr_wave_gen tmr_wave_chk #(.NCH(NCH), .WB(WB), .PIN_CH(PIN_CH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tick_i        (tick_i),
  .match_i       (match_i),
  .clk_mode_i    (clk_mode_i),
  .pulse_width_i (pulse_width_i),
  .out_invert_i  (out_invert_i),
  .out_pin_o     (out_pin_o),
  .status_o      (status_o)
);

// File: tb/tmr_wave_gen_tb.sv
module tmr_wave_gen_tb;

  logic       clk;
  logic       rst_n;
  logic [1:0] tick;
  logic [1:0] match;
  logic [1:0] cmode;
  logic [3:0] pw;
  logic       inv;
  logic       pin;
  logic [1:0] st;

  int checks;
  int failures;
  bit done;
  string tag;

  logic [1:0] m_st;
  int         m_cnt [2];
  int         obs;

  initial clk = 0;
  always #10 clk = ~clk;

  tmr_wave_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .match_i(match),
    .clk_mode_i(cmode), .pulse_width_i(pw), .out_invert_i(inv),
    .out_pin_o(pin), .status_o(st)
  );

  task automatic chk(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  // Next model state from the inputs applied this cycle.
  task automatic model_update();
    for (int c = 0; c < 2; c++) begin
      if (tick[c]) begin
        if (cmode[c]) begin
          if (match[c]) m_st[c] = ~m_st[c];
        end else if (match[c]) begin
          m_st[c] = 1'b1;
          m_cnt[c] = int'(pw[2*c +: 2]);
        end else if (m_st[c]) begin
          if (m_cnt[c] == 0) m_st[c] = 1'b0;
          else m_cnt[c]--;
        end
      end
    end
  endtask

  task automatic step(input logic [1:0] tk, input logic [1:0] mt,
                      input logic [1:0] cm, input logic [3:0] wd, input logic iv,
                      input bit rnd_tag);
    @(negedge clk);
    obs = int'(st[0]);
    for (int c = 0; c < 2; c++) begin
      string t;
      t = tag;
      if (rnd_tag) t = (c == 1) ? "R7" : (cmode[c] ? "R4" : "R2");
      chk({t, " status"}, int'(st[c]), int'(m_st[c]));
    end
    chk("R6 pin", int'(pin), int'(m_st[0] ^ inv));
    tick = tk; match = mt; cmode = cm; pw = wd; inv = iv;
    model_update();
  endtask

  initial begin
    checks = 0; failures = 0; done = 0;
    tick = 0; match = 0; cmode = 0; pw = 0; inv = 0;
    m_st = 0; m_cnt[0] = 0; m_cnt[1] = 0;
    rst_n = 0;
    // R1: reset state for both polarities
    @(negedge clk);
    chk("R1 status", int'(st), 0);
    chk("R1 pin inv0", int'(pin), 0);
    inv = 1;
    @(negedge clk);
    chk("R1 pin inv1", int'(pin), 1);
    inv = 0;
    rst_n = 1;

    // R2: each width code gives width+1 ticks of high status
    tag = "R2";
    for (int w = 0; w < 4; w++) begin
      int high;
      step(2'b01, 2'b01, 2'b00, 4'(w), 1'b0, 0);
      high = 0;
      for (int k = 0; k < 6; k++) begin
        step(2'b01, 2'b00, 2'b00, 4'(w), 1'b0, 0);
        high += obs;
      end
      chk("R2 pulse length", high, w + 1);
    end

    // R6: inverted pin during a pulse
    tag = "R6";
    step(2'b01, 2'b01, 2'b00, 4'd2, 1'b1, 0);
    repeat (5) step(2'b01, 2'b00, 2'b00, 4'd2, 1'b1, 0);

    // R3: restart while active reloads width
    tag = "R3";
    step(2'b01, 2'b01, 2'b00, 4'd3, 1'b0, 0);
    step(2'b01, 2'b00, 2'b00, 4'd3, 1'b0, 0);
    step(2'b01, 2'b01, 2'b00, 4'd1, 1'b0, 0);
    repeat (4) step(2'b01, 2'b00, 2'b00, 4'd0, 1'b0, 0);

    // R8: width change mid-pulse ignored
    tag = "R8";
    step(2'b01, 2'b01, 2'b00, 4'd0, 1'b0, 0);
    repeat (4) step(2'b01, 2'b00, 2'b00, 4'd3, 1'b0, 0);

    // R5: matches without tick ignored, both modes
    tag = "R5";
    repeat (4) step(2'b00, 2'b11, 2'b11, 4'd0, 1'b0, 0);
    repeat (4) step(2'b00, 2'b11, 2'b00, 4'd3, 1'b0, 0);

    // R4: clock mode toggling, including pin
    tag = "R4";
    repeat (6) step(2'b11, 2'b11, 2'b11, 4'd0, 1'b0, 0);
    repeat (3) step(2'b11, 2'b00, 2'b11, 4'd0, 1'b1, 0);

    // R7: channel 1 alone
    tag = "R7";
    step(2'b10, 2'b10, 2'b00, 4'b1000, 1'b0, 0);
    repeat (5) step(2'b10, 2'b00, 2'b00, 4'b0000, 1'b0, 0);

    // Random mixed phase
    begin
      int unsigned seed;
      logic [1:0] cm_r;
      logic iv_r;
      seed = $urandom(32'h5eed1234);
      cm_r = 0; iv_r = 0;
      for (int i = 0; i < 4000; i++) begin
        logic [1:0] tk_r, mt_r;
        if (($urandom % 48) == 0) cm_r = 2'($urandom);
        if (($urandom % 64) == 0) iv_r = 1'($urandom);
        tk_r = 2'($urandom) | 2'($urandom);
        mt_r = 2'($urandom) & 2'($urandom) & 2'($urandom);
        step(tk_r, mt_r, cm_r, 4'($urandom), iv_r, 1);
      end
    end
    step(2'b00, 2'b00, cmode, pw, inv, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule